// File: doc/BRIEF.md
# Masked-write GPIO bank register file

This block holds the register state for one 32-pin general-purpose I/O bank and sits behind a plain 32-bit register bus. The bus has an address, a write strobe, write data and read data. The block keeps an output latch for each pin, a direction bit and an output-enable bit. It drives the output values and the tri-state enables of the pins, and it brings the pin levels back through a synchroniser so that software can read them.

Software changes output values through two write-only half-bank ports. In each port word, the upper sixteen bits are an active-low write mask and the lower sixteen bits are the new values. A single pin can therefore be set or cleared in one write, with no read-modify-write. This also means that two agents can each own different pins of the bank without racing each other.

Top module: `gpio_bank_regs`

## Requirements
- R1: A write to offset 0x000 (low port) can change only pin_out[15:0]. pin_out[31:16] keeps its value.
- R2: A write to offset 0x004 (high port) can change only pin_out[31:16]. Bit n of the data field maps to pin 16+n, and pin_out[15:0] keeps its value.
- R3: In a port write, wdata[31:16] is the mask and wdata[15:0] is the data. Latch bit n takes data bit n when mask bit n is 0, and keeps its old value when mask bit n is 1.
- R4: A read of offset 0x000 or 0x004 returns zero.
- R5: A read of offset 0x060 returns the synchronised level of all 32 pins, with bit n for pin n. A write to offset 0x060 changes neither the outputs nor the registers.
- R6: The direction register at offset 0x204 reads back the last value written to it. A 1 in a bit marks that pin as an output.
- R7: The output-enable register at offset 0x208 reads back the last value written to it.
- R8: pin_oe[n] is 1 only when both direction bit n and output-enable bit n are 1.
- R9: A change on pin_in shows up at offset 0x060 after exactly two rising clock edges, and not after one.
- R10: After reset, pin_out, pin_oe, the direction register and the output-enable register are all zero.
- R11: A read of any other offset returns zero, and a write to any other offset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Pin levels, asynchronous to clk |
| pin_out | output | 32 | Output latch value for each pin |
| pin_oe | output | 32 | Tri-state enable for each pin, 1 drives the pin |

## Verification
The assertions assume that bus_addr, bus_we and bus_wdata settle before each rising edge and hold there. They also assume that a write strobe lasts one cycle for each intended write. The bench changes every bus input and pin_in only on the falling edge, and it pulses bus_we for exactly one cycle. The bench also sweeps every pin of both half ports, with one unmasked bit at a time. It then checks the all-masked and no-mask writes and a fixed set of direction and output-enable patterns against a model computed from the requirements.

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int OFF_LO      = 'h000,
  parameter int OFF_HI      = 'h004,
  parameter int OFF_LEVEL   = 'h060,
  parameter int OFF_DIR     = 'h204,
  parameter int OFF_OE      = 'h208
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       pin_in,
  output logic [31:0]       pin_out,
  output logic [31:0]       pin_oe
);
  localparam int NPINS = 32;
  localparam int HALF  = NPINS / 2;

  logic [NPINS-1:0] out_q, dir_q, oe_q;
  logic [NPINS-1:0] sync_q [SYNC_STAGES];
  logic [HALF-1:0]  wmask, wval;
  logic wr_lo, wr_hi, wr_dir, wr_oe;

  assign wmask  = bus_wdata[NPINS-1:HALF];
  assign wval   = bus_wdata[HALF-1:0];
  assign wr_lo  = bus_we && (bus_addr == ADDR_W'(OFF_LO));
  assign wr_hi  = bus_we && (bus_addr == ADDR_W'(OFF_HI));
  assign wr_dir = bus_we && (bus_addr == ADDR_W'(OFF_DIR));
  assign wr_oe  = bus_we && (bus_addr == ADDR_W'(OFF_OE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      oe_q  <= '0;
    end else begin
      if (wr_lo) out_q[HALF-1:0]     <= (out_q[HALF-1:0] & wmask) | (wval & ~wmask);
      if (wr_hi) out_q[NPINS-1:HALF] <= (out_q[NPINS-1:HALF] & wmask) | (wval & ~wmask);
      if (wr_dir) dir_q <= bus_wdata;
      if (wr_oe)  oe_q  <= bus_wdata;
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= '0;
        else if (s == 0) sync_q[s] <= pin_in;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pin_out = out_q;
  assign pin_oe  = dir_q & oe_q;

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFF_LEVEL): bus_rdata = sync_q[SYNC_STAGES-1];
      ADDR_W'(OFF_DIR):   bus_rdata = dir_q;
      ADDR_W'(OFF_OE):    bus_rdata = oe_q;
      default:            bus_rdata = '0;
    endcase
  end

  p_lo_spares_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFF_LO)) |=> $stable(pin_out[NPINS-1:HALF]));

  p_hi_spares_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFF_HI)) |=> $stable(pin_out[HALF-1:0]));

  p_full_mask_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFF_LO) && bus_wdata[31:16] == 16'hFFFF)
      |=> $stable(pin_out));

  p_port_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFF_LO) || bus_addr == ADDR_W'(OFF_HI)) |-> bus_rdata == '0);

  p_dir_clear_undrives_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFF_DIR) && bus_wdata == '0) |=> pin_oe == '0);

  p_level_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFF_LEVEL)) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

// File: tb/gpio_bank_regs_test.sv
`timescale 1ns/1ps
module gpio_bank_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] m_out = '0, m_dir = '0, m_oe = '0, rd;

  gpio_bank_regs uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe));

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rdreg(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [31:0] w);
    return (old & w[31:16]) | (w[15:0] & ~w[31:16]);
  endfunction

  task automatic port_wr(input int hi, input logic [31:0] w);
    wr(hi ? 12'h004 : 12'h000, w);
    if (hi) m_out[31:16] = merge(m_out[31:16], w);
    else    m_out[15:0]  = merge(m_out[15:0], w);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 pin_out", pin_out, 32'h0);
    check("R10 pin_oe", pin_oe, 32'h0);
    rdreg(12'h204, rd); check("R10 dir", rd, 32'h0);
    rdreg(12'h208, rd); check("R10 oe", rd, 32'h0);

    // R1 R2 R3: single-bit unmasked sweep, both polarities
    for (int hi = 0; hi < 2; hi++) begin
      for (int k = 0; k < 16; k++) begin
        for (int v = 0; v < 2; v++) begin
          logic [31:0] w;
          w = {~(16'h1 << k), (v == 1) ? 16'hFFFF : 16'h0000};
          port_wr(hi, w);
          check(hi ? "R2 single pin" : "R1 single pin", pin_out, m_out);
        end
        port_wr(hi, {16'h0000, 16'hA5C3 ^ 16'(k * 16'h1111)});
        check("R3 no mask", pin_out, m_out);
      end
    end
    port_wr(0, 32'hFFFF_0000 ^ 32'h0000_FFFF);
    check("R3 full mask low", pin_out, m_out);
    port_wr(1, 32'hFFFF_5A5A);
    check("R3 full mask high", pin_out, m_out);
    port_wr(1, 32'h00FF_1234);
    check("R3 partial mask", pin_out, m_out);

    rdreg(12'h000, rd); check("R4 low port read", rd, 32'h0);
    rdreg(12'h004, rd); check("R4 high port read", rd, 32'h0);

    for (int p = 0; p < 4; p++) begin
      logic [31:0] dv, ov;
      dv = 32'hF0F0_3C3C ^ (32'h0101_0101 << p);
      ov = 32'hFF00_AA55 ^ (32'h8000_0001 >> p);
      wr(12'h204, dv); m_dir = dv;
      wr(12'h208, ov); m_oe = ov;
      rdreg(12'h204, rd); check("R6 dir readback", rd, m_dir);
      rdreg(12'h208, rd); check("R7 oe readback", rd, m_oe);
      check("R8 pin_oe", pin_oe, m_dir & m_oe);
    end
    wr(12'h204, 32'h0); m_dir = 0;
    check("R8 dir cleared", pin_oe, 32'h0);
    wr(12'h204, 32'hFFFF_FFFF); m_dir = 32'hFFFF_FFFF;
    check("R8 dir all", pin_oe, m_oe);

    pin_in = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    rdreg(12'h060, rd); check("R5 level", rd, 32'hDEAD_BEEF);
    wr(12'h060, 32'h1234_5678);
    check("R5 write ignored out", pin_out, m_out);
    check("R5 write ignored oe", pin_oe, m_dir & m_oe);
    rdreg(12'h060, rd); check("R5 level kept", rd, 32'hDEAD_BEEF);

    @(negedge clk);
    bus_addr = 12'h060;
    pin_in = 32'h0F0F_0001;
    @(posedge clk); #1 check("R9 one edge", bus_rdata, 32'hDEAD_BEEF);
    @(posedge clk); #1 check("R9 two edges", bus_rdata, 32'h0F0F_0001);

    rdreg(12'h100, rd); check("R11 unmapped read", rd, 32'h0);
    rdreg(12'h064, rd); check("R11 unmapped read 2", rd, 32'h0);
    wr(12'h064, 32'hFFFF_FFFF);
    wr(12'h008, 32'h0000_FFFF);
    check("R11 write ignored out", pin_out, m_out);
    check("R11 write ignored oe", pin_oe, m_dir & m_oe);
    rdreg(12'h204, rd); check("R11 dir kept", rd, m_dir);
    rdreg(12'h208, rd); check("R11 oe kept", rd, m_oe);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule